// File: doc/BRIEF.md
# Eight-Slot I/O Port with Output Latch and Snapshot Readback

This block sits on an 8-bit I/O address space and serves one of eight port slots. A host cycle with the I/O request strobe low and an address whose five low bits are all ones selects one slot, picked by the three high address bits. A write through the block's own slot stores six bits of the data bus into a channel latch that drives six output lines. An emergency kill input switches the channel drivers off without disturbing what is stored.

A read through the same slot does not return a plain register. A snapshot register follows the six latched channel bits and the two external sensor lines on every clock. It stops following as soon as a read is seen, so the value on the bus stays steady for the whole read. Software writes a pattern, reads it straight back and compares the channel bits to confirm that the hardware is there and working. The sensor bits may change between the two accesses, so they are left out of that compare. The bus strobes are sampled on the system clock, and the tri-state read driver is modelled as a data bus plus a drive enable.

Top module: `io_chan_latch`

## Requirements
- R1: `slot_sel_n[k]` is low exactly when `iorq_n` is low, `addr[4:0]` is 5'b11111 and `addr[7:5]` equals k. At most one select is low at any time.
- R2: No even address (`addr[0]` = 0) ever pulls a slot select low. Even addresses neither change the channel latch nor enable the read driver.
- R3: When a clock edge samples a write through slot `PORT_SLOT` (default 1, address 0x3F), `chan_out` takes `wdata[5:0]` after that edge. Writes through any other slot, or with `iorq_n` high, leave `chan_out` unchanged.
- R4: After `wr_n` rises, the channel latch holds its value through idle cycles and through reads.
- R5: `rd_oe` is high only while the block's slot is selected and `rd_n` is low. It is low at every other time.
- R6: During a read, `rd_data[5:0]` holds the channel latch and `rd_data[7:6]` holds `sensor[1:0]`. Both are the values captured at the last clock edge before the read was sampled.
- R7: While a read stays active, `rd_data` does not change, even when the sensors or other inputs change.
- R8: While `kill` is high, `chan_oe` is low. The stored channel value is unchanged, and it reappears on readback and on `chan_out` once `kill` is released.
- R9: After reset, `chan_out` is 0, `chan_oe` is high (kill low) and `rd_oe` is low.
- R10: The presence probe works: writing 0x15 and then reading back gives `rd_data & 8'h3F` = 8'h15, whatever the sensor levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | I/O address bus |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 8 | Write data bus |
| sensor | input | 2 | External sensor lines |
| kill | input | 1 | Emergency disable of the channel drivers |
| rd_data | output | 8 | Read data: sensors in bits 7:6, channels in bits 5:0 |
| rd_oe | output | 1 | Read bus drive enable |
| chan_out | output | 6 | Latched channel outputs |
| chan_oe | output | 1 | Channel driver enable |
| slot_sel_n | output | 8 | Decoded port slot selects, active low |

## Verification
The slot selects and `rd_oe` are combinational from the bus inputs. The bench checks them a short delay after it changes the inputs, with no clock edge in between. `chan_out` changes at the first rising edge that samples the write, so it is checked at the falling edge after that. The bench keeps one idle edge before each read, so that the snapshot has captured the new channel value and the sensors set up ahead of it. It then checks `rd_data` as soon as the read strobe drops. It changes the sensors while the read is held across further edges and checks again, so the hold in R7 is tested against live input changes.

// File: rtl/iolatch_pkg.sv
package iolatch_pkg;
    localparam int ADDR_W_DEF = 8;
    localparam int SLOT_W_DEF = 3;
    localparam int CH_N_DEF   = 6;
    localparam int SENS_N_DEF = 2;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'b00,
        BUS_WRITE = 2'b01,
        BUS_READ  = 2'b10
    } bus_op_e;
endpackage

// File: rtl/iol_slot_decode.sv
module iol_slot_decode #(
    parameter int ADDR_W    = iolatch_pkg::ADDR_W_DEF,
    parameter int SLOT_W    = iolatch_pkg::SLOT_W_DEF,
    parameter int PORT_SLOT = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     iorq_n,
    input  logic                     rd_n,
    input  logic                     wr_n,
    output logic [(1<<SLOT_W)-1:0]   slot_sel_n,
    output iolatch_pkg::bus_op_e     op
);
    localparam int LOW_W   = ADDR_W - SLOT_W;
    localparam int SLOT_N  = 1 << SLOT_W;

    logic low_ok;
    logic [SLOT_W-1:0] slot_idx;

    assign low_ok   = &addr[LOW_W-1:0];
    assign slot_idx = addr[ADDR_W-1:LOW_W];

    for (genvar k = 0; k < SLOT_N; k++) begin : g_slot
        assign slot_sel_n[k] = !(!iorq_n && low_ok && (slot_idx == SLOT_W'(k)));
    end

    always_comb begin
        op = iolatch_pkg::BUS_IDLE;
        if (!slot_sel_n[PORT_SLOT]) begin
            if (!wr_n)      op = iolatch_pkg::BUS_WRITE;
            else if (!rd_n) op = iolatch_pkg::BUS_READ;
        end
    end

    // R1
    dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~slot_sel_n));
    // R2
    even_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr[0] |-> (&slot_sel_n));
endmodule

// File: rtl/iol_chan_latch.sv
module iol_chan_latch #(
    parameter int CH_N = iolatch_pkg::CH_N_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  iolatch_pkg::bus_op_e op,
    input  logic [CH_N-1:0]      wdata,
    output logic [CH_N-1:0]      val
);
    typedef struct packed {
        logic [CH_N-1:0] val;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (op == iolatch_pkg::BUS_WRITE) st_d.val = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val = st_q.val;

    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op != iolatch_pkg::BUS_WRITE) |=> $stable(val));
endmodule

// File: rtl/iol_snapshot.sv
module iol_snapshot #(
    parameter int CH_N   = iolatch_pkg::CH_N_DEF,
    parameter int SENS_N = iolatch_pkg::SENS_N_DEF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  iolatch_pkg::bus_op_e      op,
    input  logic [CH_N-1:0]           chan,
    input  logic [SENS_N-1:0]         sensor,
    output logic [CH_N+SENS_N-1:0]    rd_data,
    output logic                      rd_oe
);
    localparam int DATA_W = CH_N + SENS_N;

    typedef struct packed {
        logic [DATA_W-1:0] snap;
    } state_t;

    state_t st_d, st_q;
    logic   reading;

    assign reading = (op == iolatch_pkg::BUS_READ);

    always_comb begin
        st_d = st_q;
        if (!reading) st_d.snap = {sensor, chan};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.snap;
    assign rd_oe   = reading;

    // R7
    snap_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reading |=> $stable(rd_data));
endmodule

// File: rtl/io_chan_latch.sv
module io_chan_latch #(
    parameter int ADDR_W    = iolatch_pkg::ADDR_W_DEF,
    parameter int SLOT_W    = iolatch_pkg::SLOT_W_DEF,
    parameter int CH_N      = iolatch_pkg::CH_N_DEF,
    parameter int SENS_N    = iolatch_pkg::SENS_N_DEF,
    parameter int PORT_SLOT = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        iorq_n,
    input  logic                        rd_n,
    input  logic                        wr_n,
    input  logic [CH_N+SENS_N-1:0]      wdata,
    input  logic [SENS_N-1:0]           sensor,
    input  logic                        kill,
    output logic [CH_N+SENS_N-1:0]      rd_data,
    output logic                        rd_oe,
    output logic [CH_N-1:0]             chan_out,
    output logic                        chan_oe,
    output logic [(1<<SLOT_W)-1:0]      slot_sel_n
);
    localparam int DATA_W = CH_N + SENS_N;

    iolatch_pkg::bus_op_e op;
    logic [CH_N-1:0]      chan_val;
    logic                 unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:CH_N];

    iol_slot_decode #(
        .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .PORT_SLOT(PORT_SLOT)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .addr(addr), .iorq_n(iorq_n),
        .rd_n(rd_n), .wr_n(wr_n), .slot_sel_n(slot_sel_n), .op(op)
    );

    iol_chan_latch #(.CH_N(CH_N)) u_latch (
        .clk(clk), .rst_n(rst_n), .op(op),
        .wdata(wdata[CH_N-1:0]), .val(chan_val)
    );

    iol_snapshot #(.CH_N(CH_N), .SENS_N(SENS_N)) u_snap (
        .clk(clk), .rst_n(rst_n), .op(op), .chan(chan_val),
        .sensor(sensor), .rd_data(rd_data), .rd_oe(rd_oe)
    );

    assign chan_out = chan_val;
    assign chan_oe  = !kill;

    // R5
    rd_oe_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> (!rd_n && !iorq_n && !slot_sel_n[PORT_SLOT]));
    // R8
    kill_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && wr_n) |=> $stable(chan_out));
endmodule

// File: tb/io_chan_latch_test.sv
module io_chan_latch_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = 8'h00;
    logic       iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] wdata = 8'h00;
    logic [1:0] sensor = 2'b00;
    logic       kill = 1'b0;
    logic [7:0] rd_data;
    logic       rd_oe;
    logic [5:0] chan_out;
    logic       chan_oe;
    logic [7:0] slot_sel_n;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [5:0] exp_out = 6'h00;

    localparam logic [7:0] MY_PORT = 8'h3F;

    always #4 clk = ~clk;

    io_chan_latch uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .iorq_n(iorq_n),
        .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata), .sensor(sensor),
        .kill(kill), .rd_data(rd_data), .rd_oe(rd_oe),
        .chan_out(chan_out), .chan_oe(chan_oe), .slot_sel_n(slot_sel_n)
    );

    function automatic logic [7:0] exp_sel(input logic [7:0] a, input logic iq);
        logic [7:0] s = 8'hFF;
        if (!iq && a[4:0] == 5'h1F) s[a[7:5]] = 1'b0;
        return s;
    endfunction

    function automatic bit hits(input logic [7:0] a);
        return a == MY_PORT;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; iorq_n = 1'b0; wr_n = 1'b0;
        #1;
        check(slot_sel_n == exp_sel(a, 1'b0), "R1 write select", slot_sel_n, exp_sel(a, 1'b0));
        if (!a[0]) check(&slot_sel_n, "R2 even write", slot_sel_n, 8'hFF);
        @(negedge clk);
        wr_n = 1'b1; iorq_n = 1'b1;
        if (hits(a)) exp_out = d[5:0];
        check(chan_out == exp_out, "R3 write result", chan_out, exp_out);
        @(negedge clk);
        check(chan_out == exp_out, "R4 hold after WR", chan_out, exp_out);
    endtask

    task automatic do_read(input logic [7:0] a, input logic [1:0] s);
        logic [7:0] expd;
        @(negedge clk);
        sensor = s;
        @(negedge clk);
        addr = a; iorq_n = 1'b0; rd_n = 1'b0;
        #1;
        expd = {s, exp_out};
        check(rd_oe == hits(a), "R5 read enable", rd_oe, hits(a));
        check(slot_sel_n == exp_sel(a, 1'b0), "R1 read select", slot_sel_n, exp_sel(a, 1'b0));
        if (hits(a)) begin
            check(rd_data == expd, "R6 read data", rd_data, expd);
            @(negedge clk);
            sensor = ~s;
            @(negedge clk);
            check(rd_data == expd, "R7 frozen during read", rd_data, expd);
            check(chan_out == exp_out, "R4 hold through read", chan_out, exp_out);
        end
        @(negedge clk);
        rd_n = 1'b1; iorq_n = 1'b1;
        #1;
        check(rd_oe == 1'b0, "R5 enable off after read", rd_oe, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h0C0FFEE);
        repeat (3) @(negedge clk);
        // R9 reset state
        check(chan_out == 6'h00, "R9 reset chan_out", chan_out, 0);
        check(chan_oe == 1'b1, "R9 reset chan_oe", chan_oe, 1);
        check(rd_oe == 1'b0, "R9 reset rd_oe", rd_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(chan_out == 6'h00, "R9 after release", chan_out, 0);

        // R10 presence probe
        do_write(MY_PORT, 8'h15);
        do_read(MY_PORT, 2'b10);
        check((rd_data & 8'h3F) == 8'h15, "R10 presence", rd_data & 8'h3F, 8'h15);

        // R3 other slots and iorq high ignored
        do_write(8'h5F, 8'h2A);
        do_write(8'hFF, 8'h3F);
        @(negedge clk);
        addr = MY_PORT; wdata = 8'h3F; wr_n = 1'b0; iorq_n = 1'b1;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        check(chan_out == exp_out, "R3 iorq high ignored", chan_out, exp_out);
        // R2 even addresses ignored
        do_write(8'h3E, 8'h3F);
        do_read(8'h3E, 2'b01);
        do_read(MY_PORT, 2'b01);

        // R8 kill keeps store
        do_write(MY_PORT, 8'h2D);
        @(negedge clk);
        kill = 1'b1;
        #1;
        check(chan_oe == 1'b0, "R8 kill disables", chan_oe, 0);
        do_read(MY_PORT, 2'b11);
        check(chan_out == 6'h2D, "R8 store unchanged", chan_out, 6'h2D);
        @(negedge clk);
        kill = 1'b0;
        #1;
        check(chan_oe == 1'b1 && chan_out == 6'h2D, "R8 release", {chan_oe, chan_out}, {1'b1, 6'h2D});

        // random mix
        for (int i = 0; i < 200; i++) begin
            logic [7:0] a;
            logic [7:0] d;
            d = 8'($urandom);
            if ($urandom % 10 < 6) a = {3'($urandom), 5'h1F};
            else a = 8'($urandom);
            if ($urandom % 2 == 0) do_write(a, d);
            else do_read(a, 2'($urandom));
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule